// File: doc/BRIEF.md
# Range-Limited Permutation Sequence Generator

This block hands out, one value per request, the integers 0 to N-1 in a scrambled order in which no value repeats until all N have appeared. N is set at run time and does not have to be a power of two. No table of already-issued values is kept. A full-period linear congruential recurrence runs over a power-of-two space of size M. M is the smallest power of two that is not below N, so N <= M < 2N. Each state is optionally scrambled by an XOR mask and shifted by a configurable base, modulo M. States that land outside 0..N-1 are skipped and the recurrence steps again. Fewer than half of all states are ever skipped.

Software loads a configuration with a one-cycle load strobe. The configuration holds the length, the multiplier, the increment, the seed, the base and the XOR mask. A configuration that cannot give a full period is refused and the error output is raised. After that, each one-cycle request pulse starts a search, which takes one recurrence step per clock. The search ends by presenting the value with a valid flag, and the value is held until the next request or the next load.

Top module: `perm_seq_gen`

## Requirements
- R1: After reset, `out_valid` and `cfg_err` are 0, and a request made before any configuration is loaded never raises `out_valid`.
- R2: On a load where `cfg_len` is 0 or greater than 2^W, or `cfg_inc` is even, or `cfg_mult` mod 8 is not 5, `cfg_err` reads 1 from the next cycle on. In that state requests never raise `out_valid`.
- R3: On a load of a legal configuration, `cfg_err` reads 0 and `out_valid` reads 0 from the next cycle on. The internal state becomes `cfg_seed` mod M, where M is the smallest power of two >= `cfg_len`.
- R4: Each search repeats two steps. First it updates the state x to (`cfg_mult`*x + `cfg_inc`) mod M. Then it forms off = (((x XOR `cfg_xmask`) mod M) - `cfg_base`) mod M. The search ends at the first step where off < `cfg_len`, and that off appears on `out_value`.
- R5: Any `cfg_len` consecutive results after a load are all distinct and all below `cfg_len`.
- R6: The sequence is periodic with period `cfg_len` results: result k+N equals result k.
- R7: A search takes exactly as many clock cycles as recurrence steps, which is at least 1 and at most M. `out_valid` rises that many cycles after the edge that samples the request.
- R8: While `out_valid` is 1 and neither `req` nor `cfg_load` is asserted, `out_valid` stays 1 and `out_value` does not change.
- R9: A request that arrives while a search is running is ignored and leaves the sequence unchanged.
- R10: The corner lengths work: N = 1 always yields 0 after one cycle, and N = 2^W yields a result on every step with no skipping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration and restarts the sequence |
| cfg_len | input | W+1 | Range length N |
| cfg_mult | input | W | Recurrence multiplier (must be 5 mod 8) |
| cfg_inc | input | W | Recurrence increment (must be odd) |
| cfg_seed | input | W | Starting state, taken mod M |
| cfg_base | input | W | Subrange start, subtracted mod M |
| cfg_xmask | input | W | XOR scramble applied to each state, taken mod M |
| req | input | 1 | One-cycle request for the next value |
| out_valid | output | 1 | Result present |
| out_value | output | W | Current result, 0..N-1 |
| cfg_err | output | 1 | Last loaded configuration was refused |

## Verification
A wrong state register or a wrong recurrence shows up on the first request after a load: the value differs from the bench model, or the search takes a different number of cycles than the model's step count. A corrupted acceptance test or a wrong modulus mask gives either an out-of-range value or a repeated value. The distinctness check catches a repeat within N results. A wrong period becomes visible when the second pass over N results differs from the first.

// File: rtl/perm_seq_pkg.sv
package perm_seq_pkg;
    typedef enum logic [1:0] {
        ST_UNCFG  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SEARCH = 2'd2,
        ST_FAULT  = 2'd3
    } psg_state_e;

    localparam logic [2:0] MULT_RESIDUE = 3'b101;
endpackage

// File: rtl/psg_cfg_check.sv
module psg_cfg_check #(
    parameter int W = 12
) (
    input  logic [W:0]   len,
    input  logic [W-1:0] mult,
    input  logic [W-1:0] inc,
    output logic [W-1:0] mod_mask,
    output logic         bad
);
    import perm_seq_pkg::*;

    localparam int STAGES = $clog2(W);
    localparam logic [W:0] LEN_MAX = {1'b1, {W{1'b0}}};

    logic [W-1:0] len_m1;
    logic [W-1:0] smear [0:STAGES];

    assign len_m1   = len[W-1:0] - {{(W-1){1'b0}}, 1'b1};
    assign smear[0] = len_m1;

    // Fill every bit below the top set bit: M-1 for the smallest power of two >= len
    for (genvar g = 0; g < STAGES; g++) begin : g_smear
        assign smear[g+1] = smear[g] | (smear[g] >> (1 << g));
    end

    assign mod_mask = smear[STAGES];
    assign bad = (len == '0) || (len > LEN_MAX) || !inc[0] || (mult[2:0] != MULT_RESIDUE);
endmodule

// File: rtl/psg_lcg_step.sv
module psg_lcg_step #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] mult,
    input  logic [W-1:0] inc,
    input  logic [W-1:0] mod_mask,
    output logic [W-1:0] x_next
);
    logic [W-1:0] prod;
    assign prod   = mult * x;
    assign x_next = (prod + inc) & mod_mask;
endmodule

// File: rtl/psg_range_filter.sv
module psg_range_filter #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] xmask,
    input  logic [W-1:0] base,
    input  logic [W-1:0] mod_mask,
    input  logic [W:0]   len,
    output logic [W-1:0] offset,
    output logic         accept
);
    logic [W-1:0] scrambled;
    assign scrambled = (x ^ xmask) & mod_mask;
    assign offset    = (scrambled - base) & mod_mask;
    assign accept    = ({1'b0, offset} < len);
endmodule

// File: rtl/perm_seq_gen.sv
module perm_seq_gen #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_load,
    input  logic [W:0]   cfg_len,
    input  logic [W-1:0] cfg_mult,
    input  logic [W-1:0] cfg_inc,
    input  logic [W-1:0] cfg_seed,
    input  logic [W-1:0] cfg_base,
    input  logic [W-1:0] cfg_xmask,
    input  logic         req,
    output logic         out_valid,
    output logic [W-1:0] out_value,
    output logic         cfg_err
);
    import perm_seq_pkg::*;

    typedef struct packed {
        psg_state_e   state;
        logic [W-1:0] x;
        logic [W:0]   steps;
        logic         valid;
        logic [W-1:0] value;
        logic [W:0]   len;
        logic [W-1:0] mult;
        logic [W-1:0] inc;
        logic [W-1:0] base;
        logic [W-1:0] xmask;
        logic [W-1:0] mmask;
        logic         err;
    } regs_t;

    regs_t r_q, r_d;

    logic [W-1:0] load_mask;
    logic         load_bad;
    logic [W-1:0] x_next;
    logic [W-1:0] offset;
    logic         accept;

    psg_cfg_check #(.W(W)) u_check (
        .len      (cfg_len),
        .mult     (cfg_mult),
        .inc      (cfg_inc),
        .mod_mask (load_mask),
        .bad      (load_bad)
    );

    psg_lcg_step #(.W(W)) u_step (
        .x        (r_q.x),
        .mult     (r_q.mult),
        .inc      (r_q.inc),
        .mod_mask (r_q.mmask),
        .x_next   (x_next)
    );

    psg_range_filter #(.W(W)) u_filter (
        .x        (x_next),
        .xmask    (r_q.xmask),
        .base     (r_q.base),
        .mod_mask (r_q.mmask),
        .len      (r_q.len),
        .offset   (offset),
        .accept   (accept)
    );

    always_comb begin
        r_d = r_q;
        if (cfg_load) begin
            r_d.len   = cfg_len;
            r_d.mult  = cfg_mult;
            r_d.inc   = cfg_inc;
            r_d.base  = cfg_base;
            r_d.xmask = cfg_xmask;
            r_d.mmask = load_mask;
            r_d.err   = load_bad;
            r_d.x     = cfg_seed & load_mask;
            r_d.valid = 1'b0;
            r_d.steps = '0;
            r_d.state = load_bad ? ST_FAULT : ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (req) begin
                        r_d.valid = 1'b0;
                        r_d.steps = '0;
                        r_d.state = ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    r_d.x = x_next;
                    if (accept) begin
                        r_d.value = offset;
                        r_d.valid = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.steps = r_q.steps + {{W{1'b0}}, 1'b1};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_UNCFG;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.valid;
    assign out_value = r_q.value;
    assign cfg_err   = r_q.err;

    // A refused configuration never produces results
    assert_fault_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !out_valid);

    // Every presented result lies inside the configured range
    assert_result_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_value} < r_q.len));

    // A search never needs more steps than the power-of-two space holds
    assert_search_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SEARCH) |-> (r_q.steps <= {1'b0, r_q.mmask}));

    // A result only appears at the end of a search
    assert_valid_from_search_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(r_q.state == ST_SEARCH));

    // An idle result is held untouched
    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !req && !cfg_load) |=> (out_valid && $stable(out_value)));
endmodule

// File: tb/perm_seq_gen_tb.sv
module perm_seq_gen_tb_top;
    localparam int W = 12;
    localparam int NMAX = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_load = 1'b0;
    logic [W:0]   cfg_len = '0;
    logic [W-1:0] cfg_mult = '0, cfg_inc = '0, cfg_seed = '0, cfg_base = '0, cfg_xmask = '0;
    logic         req = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_value;
    logic         cfg_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of the configured sequence
    int unsigned m_len, m_mult, m_inc, m_base, m_xmask, m_mod, m_x;
    int unsigned exp_val, exp_steps;
    int first_pass [0:NMAX-1];
    bit seen [0:NMAX-1];

    always #5 clk = ~clk;

    perm_seq_gen #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_len(cfg_len),
        .cfg_mult(cfg_mult), .cfg_inc(cfg_inc), .cfg_seed(cfg_seed),
        .cfg_base(cfg_base), .cfg_xmask(cfg_xmask), .req(req),
        .out_valid(out_valid), .out_value(out_value), .cfg_err(cfg_err)
    );

    function automatic int unsigned pow2_at_least(int unsigned n);
        int unsigned m = 1;
        while (m < n) m = m * 2;
        return m;
    endfunction

    task automatic check(bit ok, string rq, int unsigned act, int unsigned expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    task automatic model_next();
        int unsigned off;
        exp_steps = 0;
        forever begin
            m_x = (m_mult * m_x + m_inc) % m_mod;
            exp_steps++;
            off = (((m_x ^ m_xmask) % m_mod) + m_mod - (m_base % m_mod)) % m_mod;
            if (off < m_len) begin
                exp_val = off;
                break;
            end
        end
    endtask

    task automatic load_cfg(int unsigned n, int unsigned a, int unsigned c, int unsigned s,
                            int unsigned b, int unsigned xm, bit expect_err, string rq);
        @(negedge clk);
        cfg_len = (W+1)'(n); cfg_mult = W'(a); cfg_inc = W'(c);
        cfg_seed = W'(s); cfg_base = W'(b); cfg_xmask = W'(xm);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        check(cfg_err == expect_err, rq, cfg_err, expect_err);
        check(out_valid == 1'b0, rq, out_valid, 0);
        if (!expect_err) begin
            m_len = n; m_mult = a % NMAX; m_inc = c % NMAX; m_base = b % NMAX;
            m_mod = pow2_at_least(n);
            m_xmask = (xm % NMAX) % m_mod;
            m_x = (s % NMAX) % m_mod;
        end
    endtask

    // returns value seen and cycle count; hold2 keeps req high into the search (R9)
    task automatic request(bit hold2, output int unsigned val, output int unsigned cyc);
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = hold2;
        cyc = 0;
        while (cyc <= NMAX + 2) begin
            @(negedge clk);
            req = 1'b0;
            cyc++;
            if (out_valid) break;
        end
        val = out_value;
    endtask

    task automatic run_seq(int unsigned count, bit hold2, bit full_check, string tag);
        int unsigned v, cyc;
        for (int i = 0; i < NMAX; i++) seen[i] = 0;
        for (int unsigned k = 0; k < count; k++) begin
            model_next();
            request(hold2, v, cyc);
            check(out_valid == 1'b1 && v == exp_val, {"R4 ", tag}, v, exp_val);
            check(cyc == exp_steps && cyc <= m_mod, {"R7 ", tag}, cyc, exp_steps);
            if (hold2) check(v == exp_val, {"R9 ", tag}, v, exp_val);
            if (full_check) begin
                if (k < m_len) begin
                    check(v < m_len && !seen[v], {"R5 ", tag}, v, m_len);
                    if (v < NMAX) seen[v] = 1;
                    first_pass[k] = int'(v);
                end else begin
                    check(v == first_pass[k - m_len], {"R6 ", tag}, v, first_pass[k - m_len]);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned v, cyc, held;
        void'($urandom(17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(cfg_err == 1'b0, "R1 reset err", cfg_err, 0);
        request(1'b0, v, cyc);
        check(out_valid == 1'b0, "R1 request before config", out_valid, 0);

        // refused configurations
        load_cfg(0, 5, 1, 0, 0, 0, 1'b1, "R2 zero length");
        load_cfg(NMAX + 1, 5, 1, 0, 0, 0, 1'b1, "R2 length too large");
        load_cfg(10, 5, 2, 0, 0, 0, 1'b1, "R2 even increment");
        load_cfg(10, 3, 1, 0, 0, 0, 1'b1, "R2 bad multiplier");
        request(1'b0, v, cyc);
        check(out_valid == 1'b0, "R2 request while refused", out_valid, 0);

        // N = 1 corner
        load_cfg(1, 13, 7, 0, 0, 0, 1'b0, "R3 len one");
        run_seq(4, 1'b0, 1'b0, "R10 len one");

        // small non-power-of-two with base and scramble
        load_cfg(5, 5, 1, 2, 3, 6, 1'b0, "R3 len five");
        run_seq(10, 1'b0, 1'b1, "len five");

        // hold behaviour
        request(1'b0, v, cyc);
        model_next();
        check(v == exp_val, "R4 before hold", v, exp_val);
        held = out_value;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b1 && out_value == held, "R8 hold", out_value, held);

        // requests during a running search are ignored
        load_cfg(100, 21, 33, 77, 5, 200, 1'b0, "R3 len hundred");
        run_seq(200, 1'b1, 1'b1, "R9 len hundred");

        // reload restarts the sequence from the seed
        load_cfg(100, 21, 33, 77, 5, 200, 1'b0, "R3 reload");
        run_seq(20, 1'b0, 1'b0, "reload");

        // full-width space: no skipping
        load_cfg(NMAX, 4093, 1235, 9, 0, 55, 1'b0, "R3 full width");
        run_seq(NMAX, 1'b0, 1'b1, "R10 full width");

        // just above a power of two: nearly half skipped
        load_cfg(NMAX / 2 + 1, 2053, 11, 100, 4000, 7, 1'b0, "R3 half plus one");
        run_seq(NMAX / 2 + 1, 1'b0, 1'b1, "half plus one");

        // constrained random configurations
        for (int t = 0; t < 5; t++) begin
            int unsigned n;
            n = $urandom_range(2, 900);
            load_cfg(n, ($urandom & 32'hFF8) | 5, $urandom | 1, $urandom, $urandom,
                     $urandom, 1'b0, "R3 random");
            run_seq(2 * n, (t % 2) == 1, 1'b1, "random");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule